// File: doc/BRIEF.md
# Phase-Offset Clock Output Divider

This block is one output channel of a clock distribution stage. It divides its input clock by any integer from 1 to 1024 and can delay its output by a programmable number of input half periods. A level-sensitive sync request shared by many channels holds every participating channel at its idle level. On release, all of them restart together, each after its own phase delay. A channel can be told to ignore sync, and it then keeps running undisturbed.

Configuration arrives as a 24-bit word. The channel samples it only on a one-cycle update strobe and keeps it in a shadow register until it is safe to apply. A running channel applies a pending word at the end of its current output period, so it never emits a runt pulse. A channel that is held or powered down applies the word at once.

The channel also offers output inversion and power-down. A 4-bit driver-mode field and a low-power flag pass through to the analog driver that sits outside this block. Internally the channel works in half-period steps of the input clock. It computes the two halves of each input cycle on the rising edge, and a final multiplexer, steered by the input clock, selects between them.

Top module: `phase_clk_divider`

## Requirements
- R1: While reset is low, clk_o is low. After reset the active configuration is the all-zero word: ratio 1, no phase delay, no inversion, not powered down, driver mode 0 and low power 0. The output then follows the input clock.
- R2: Bits 17:8 hold the division ratio N minus one. For even N the output is high for N/2 input periods and low for N/2 input periods.
- R3: For odd N greater than 1, the output is high for (N+1)/2 input periods and low for (N-1)/2 input periods. For N = 1 the output is high during the high phase of the input clock and low during its low phase.
- R4: Bits 23:18 hold a phase code P (0 to 63). The release edge is the first rising input edge at which sync_i is sampled low after a hold. The output stays at its idle level for P input half periods from the release edge, and then starts a new period with its high part. A new phase code takes effect at the next hold release.
- R5: While sync_i is high and bit 6 is clear, the output sits at its idle level. The idle level is low, or high when bit 7 is set. The period restarts on release as given in R4.
- R6: With bit 6 set, sync_i has no effect on the output.
- R7: Bit 7 inverts the output, including its idle level.
- R8: With bit 5 set, clk_o is low whatever the inversion bit and whatever sync_i does, and the period counter is frozen.
- R9: cfg_i is sampled only at a rising edge where update_i is high. A running channel applies a pending word at the end of its current output period. If a second update arrives before that boundary, the second word replaces the first.
- R10: A word that is pending while the channel is held or powered down is applied at the update edge. The channel then starts a fresh period after the new word's phase delay.
- R11: drv_mode_o carries bits 3:0 and low_power_o carries bit 4 of the active word. Both change just after the edge at which that word is applied.
- R12: The largest ratio (1024) and the largest phase code (63) work as in R2 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 24 | Configuration word, sampled on update |
| update_i | input | 1 | One-cycle strobe that loads cfg_i into the shadow register |
| sync_i | input | 1 | Shared sync request, high holds participating channels |
| clk_o | output | 1 | Divided, phase-shifted clock |
| drv_mode_o | output | 4 | Driver-mode field of the active word |
| low_power_o | output | 1 | Low-power flag of the active word |

## Verification
The channel samples update_i and sync_i on a rising edge. The two output halves computed at that edge appear at once: half 0 in the high phase that follows the edge and half 1 in the low phase after it. The bench therefore numbers half periods from the update or release edge. It samples clk_o 5 ns after each rising and each falling edge and compares every half against a pattern computed from N, P and the inversion bit. A word that is pending on a running channel shows up only at the half that follows the last half of the current period. The bench positions its updates at known half indices so that this boundary, and the overwrite of a pending word, land on fixed samples. drv_mode_o and low_power_o are checked at the falling edge that follows the applying edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CFG_W    = 24;
    localparam int RATIO_W  = 10;
    localparam int PHASE_W  = 6;
    localparam int DRV_W    = 4;
    localparam int POS_W    = RATIO_W + 1;
    localparam int HALVES   = 2;

    // Field order matches the configuration word, MSB first.
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [RATIO_W-1:0] ratio_m1;
        logic               inv;
        logic               ign;
        logic               pd;
        logic               lowpwr;
        logic [DRV_W-1:0]   drv;
    } chan_cfg_t;

    typedef struct packed {
        chan_cfg_t          act;
        chan_cfg_t          shadow;
        logic               pend;
        logic [POS_W-1:0]   pos;
        logic [PHASE_W-1:0] dly;
    } div_state_t;

    typedef struct packed {
        div_state_t         st;
        logic [HALVES-1:0]  half;
    } div_reg_t;

    // Number of high half-ticks inside one output period of 2N half-ticks.
    function automatic logic [POS_W-1:0] high_len(input logic [RATIO_W-1:0] m);
        logic [POS_W-1:0] n;
        n = POS_W'(m) + POS_W'(1);
        if (m == '0) begin
            return POS_W'(1);
        end else if (n[0]) begin
            return n + POS_W'(1);
        end else begin
            return n;
        end
    endfunction

    // Index of the last half-tick of a period: 2N-1.
    function automatic logic [POS_W-1:0] last_pos(input logic [RATIO_W-1:0] m);
        return {m, 1'b1};
    endfunction

endpackage

// File: rtl/clkdiv_cfg_stage.sv
module clkdiv_cfg_stage
    import clkdiv_pkg::*;
(
    input  div_state_t        st_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              update_i,
    input  logic              sync_i,
    output div_state_t        st_o,
    output logic              run_o
);

    div_state_t s;
    logic       held;

    always_comb begin
        s = st_i;

        // Capture into the shadow; a later strobe overwrites a pending word.
        if (update_i) begin
            s.shadow = chan_cfg_t'(cfg_i);
            s.pend   = 1'b1;
        end

        // Idle channels (powered down or held) may switch immediately.
        if (s.pend && (s.act.pd || (sync_i && !s.act.ign))) begin
            s.act  = s.shadow;
            s.pend = 1'b0;
            s.pos  = '0;
            s.dly  = s.shadow.phase;
        end

        held = sync_i && !s.act.ign && !s.act.pd;

        // Hold: park at period start with the phase delay preloaded.
        if (held) begin
            s.pos = '0;
            s.dly = s.act.phase;
        end

        run_o = !s.act.pd && !held;
        st_o  = s;
    end

endmodule

// File: rtl/clkdiv_half_step.sv
module clkdiv_half_step
    import clkdiv_pkg::*;
(
    input  div_state_t st_i,
    output div_state_t st_o,
    output logic       bit_o
);

    logic [POS_W-1:0] hi_len;
    logic [POS_W-1:0] end_pos;

    always_comb begin
        hi_len  = high_len(st_i.act.ratio_m1);
        end_pos = last_pos(st_i.act.ratio_m1);
        st_o    = st_i;
        bit_o   = 1'b0;

        if (!st_i.act.pd) begin
            if (st_i.dly != '0) begin
                // Still inside the phase delay: idle level.
                st_o.dly = st_i.dly - PHASE_W'(1);
                bit_o    = st_i.act.inv;
            end else begin
                bit_o = (st_i.pos < hi_len) ^ st_i.act.inv;
                if (st_i.pos == end_pos) begin
                    // Period boundary: safe point for a pending word.
                    st_o.pos = '0;
                    if (st_i.pend) begin
                        st_o.act  = st_i.shadow;
                        st_o.pend = 1'b0;
                    end
                end else begin
                    st_o.pos = st_i.pos + POS_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/clkdiv_out_sel.sv
module clkdiv_out_sel
    import clkdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic [HALVES-1:0] half_i,
    output logic              clk_o
);

    // Half 0 covers the high phase after the edge, half 1 the low phase.
    assign clk_o = clk_i ? half_i[0] : half_i[HALVES-1];

endmodule

// File: rtl/phase_clk_divider.sv
module phase_clk_divider
    import clkdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              update_i,
    input  logic              sync_i,
    output logic              clk_o,
    output logic [DRV_W-1:0]  drv_mode_o,
    output logic              low_power_o
);

    div_reg_t          r_d, r_q;
    div_state_t        pre_st;
    logic              run;
    div_state_t        chain [HALVES+1];
    logic [HALVES-1:0] step_bits;

    clkdiv_cfg_stage u_cfg_stage (
        .st_i     (r_q.st),
        .cfg_i    (cfg_i),
        .update_i (update_i),
        .sync_i   (sync_i),
        .st_o     (pre_st),
        .run_o    (run)
    );

    assign chain[0] = pre_st;

    // One step per half period of the input clock.
    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            clkdiv_half_step u_step (
                .st_i  (chain[h]),
                .st_o  (chain[h+1]),
                .bit_o (step_bits[h])
            );
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (run) begin
            r_d.st   = chain[HALVES];
            r_d.half = step_bits;
        end else begin
            r_d.st   = pre_st;
            r_d.half = pre_st.act.pd ? '0 : {HALVES{pre_st.act.inv}};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drv_mode_o  = r_q.st.act.drv;
    assign low_power_o = r_q.st.act.lowpwr;

    clkdiv_out_sel u_out_sel (
        .clk_i  (clk_i),
        .half_i (r_q.half),
        .clk_o  (clk_o)
    );

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
    import clkdiv_pkg::*;
(
    input logic     clk_i,
    input logic     rst_ni,
    input logic     update_i,
    input logic     sync_i,
    input div_reg_t r_q
);

    // R2: the half-tick position never leaves the 2N-long period.
    p_pos_in_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.st.pos <= {r_q.st.act.ratio_m1, 1'b1})
        else $error("position beyond period end");

    // R5: a participating channel that saw sync holds its idle level.
    p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(sync_i) && !r_q.st.act.ign && !r_q.st.act.pd)
        |-> (r_q.half == {HALVES{r_q.st.act.inv}}))
        else $error("held channel not at idle level");

    // R8: while powered down with an unchanged word the counter is frozen.
    p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st.act.pd && $stable(r_q.st.act)) |-> $stable(r_q.st.pos))
        else $error("counter moved while powered down");

    // R8: a powered-down channel drives low in both halves.
    p_pd_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(r_q.st.act.pd) && r_q.st.act.pd) |-> (r_q.half == '0))
        else $error("powered-down channel not low");

    // R9: without an update strobe the shadow word keeps its value.
    p_shadow_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !update_i |=> $stable(r_q.st.shadow))
        else $error("shadow changed without update");

endmodule

bind phase_clk_divider clkdiv_checker u_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (update_i),
    .sync_i   (sync_i),
    .r_q      (r_q)
);

// File: tb/phase_clk_divider_bench.sv
`timescale 1ns/1ps
module phase_clk_divider_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] cfg;
    logic        upd;
    logic        sync;
    logic        clk_out;
    logic [3:0]  drv;
    logic        lp;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    phase_clk_divider u_phase_clk_divider (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_i       (cfg),
        .update_i    (upd),
        .sync_i      (sync),
        .clk_o       (clk_out),
        .drv_mode_o  (drv),
        .low_power_o (lp)
    );

    function automatic logic [23:0] mk(int p, int n, bit inv, bit ign, bit pd, bit lpw, int dm);
        logic [9:0] r;
        r = 10'(n - 1);
        return {6'(p), r, inv, ign, pd, lpw, 4'(dm)};
    endfunction

    // Expected half-tick value counted from the release edge.
    function automatic bit exp_half(int n, int p, bit inv, int idx);
        int k;
        int h;
        if (idx < p) return inv;
        k = (idx - p) % (2 * n);
        h = (n == 1) ? 1 : ((n % 2 == 1) ? n + 1 : n);
        return (k < h) ^ inv;
    endfunction

    task automatic check_val(string req, int act, int exp, int idx);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s half %0d: got %0d expected %0d", req, idx, act, exp);
        end
    endtask

    // Samples 'count' halves starting at the next rising edge. Halves from sw on
    // follow a second word (ratio n2, inversion inv2, or low when pd2).
    task automatic watch2(string req, int n1, int p1, bit inv1, int sw,
                          int n2, bit inv2, bit pd2, int count);
        for (int i = 0; i < count; i += 2) begin
            for (int j = 0; j < 2; j++) begin
                bit e;
                if (j == 0) @(posedge clk); else @(negedge clk);
                #5;
                if (i + j < sw) e = exp_half(n1, p1, inv1, i + j);
                else if (pd2) e = 1'b0;
                else e = exp_half(n2, 0, inv2, i + j - sw);
                check_val(req, int'(clk_out), int'(e), i + j);
            end
        end
    endtask

    task automatic watch(string req, int n, int p, bit inv, int count);
        watch2(req, n, p, inv, count, 1, 1'b0, 1'b0, count);
    endtask

    // Loads a word while holding sync, checks pass-through fields and idle
    // level, then drops sync; returns at the falling edge before release.
    task automatic program_held(logic [23:0] w);
        @(negedge clk);
        cfg = w; upd = 1'b1; sync = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        check_val("R11 drv", int'(drv), int'(w[3:0]), -1);
        check_val("R11 lowpwr", int'(lp), int'(w[4]), -1);
        #5 check_val("R5 idle low phase", int'(clk_out), int'(w[7]), -1);
        @(posedge clk);
        #5 check_val("R5 idle high phase", int'(clk_out), int'(w[7]), -1);
        @(negedge clk);
        sync = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg = '0; upd = 1'b0; sync = 1'b0;
        repeat (2) @(posedge clk);
        #5 check_val("R1 reset high phase", int'(clk_out), 0, -1);
        @(negedge clk);
        #5 check_val("R1 reset low phase", int'(clk_out), 0, -1);
        cfg = mk(5, 7, 1, 0, 0, 1, 9);   // not loaded: no update strobe
        @(negedge clk);
        rst_n = 1'b1;
        watch("R1", 1, 0, 1'b0, 8);
        check_val("R1 drv", int'(drv), 0, -1);
        check_val("R1 lowpwr", int'(lp), 0, -1);
    endtask

    task automatic t_even();
        program_held(mk(0, 4, 0, 0, 0, 1, 5));
        watch("R2 N=4", 4, 0, 1'b0, 32);
        program_held(mk(0, 6, 0, 0, 0, 0, 3));
        watch("R2 N=6", 6, 0, 1'b0, 36);
    endtask

    task automatic t_odd();
        program_held(mk(0, 3, 0, 0, 0, 0, 1));
        watch("R3 N=3", 3, 0, 1'b0, 36);
        program_held(mk(0, 5, 0, 0, 0, 0, 2));
        watch("R3 N=5", 5, 0, 1'b0, 40);
        program_held(mk(0, 1, 0, 0, 0, 0, 0));
        watch("R3 N=1", 1, 0, 1'b0, 10);
    endtask

    task automatic t_phase();
        program_held(mk(3, 4, 0, 0, 0, 0, 7));
        watch("R4 P=3", 4, 3, 1'b0, 40);
        program_held(mk(5, 2, 0, 0, 0, 0, 6));
        watch("R4 P=5", 2, 5, 1'b0, 30);
    endtask

    task automatic t_invert();
        program_held(mk(2, 2, 1, 0, 0, 0, 4));
        watch("R7", 2, 2, 1'b1, 24);
    endtask

    task automatic t_power();
        program_held(mk(0, 2, 0, 0, 0, 0, 0));
        fork
            watch2("R8", 2, 0, 1'b0, 4, 1, 1'b0, 1'b1, 28);
            begin
                @(negedge clk);
                cfg = mk(0, 2, 1, 0, 1, 0, 0); upd = 1'b1;
                @(negedge clk);
                upd = 1'b0;
                repeat (3) @(negedge clk);
                sync = 1'b1;
                repeat (3) @(negedge clk);
                sync = 1'b0;
            end
        join
        @(negedge clk);
        cfg = mk(2, 2, 0, 0, 0, 0, 0); upd = 1'b1;
        fork
            watch("R10", 2, 2, 1'b0, 24);
            begin
                @(negedge clk);
                upd = 1'b0;
            end
        join
    endtask

    task automatic t_shadow();
        program_held(mk(0, 4, 0, 0, 0, 0, 0));
        fork
            watch2("R9", 4, 0, 1'b0, 8, 3, 1'b0, 1'b0, 32);
            begin
                @(negedge clk);
                cfg = mk(0, 2, 0, 0, 0, 0, 0); upd = 1'b1;
                @(negedge clk);
                cfg = mk(0, 3, 0, 0, 0, 0, 0); upd = 1'b1;
                @(negedge clk);
                upd = 1'b0;
                cfg = mk(0, 5, 1, 0, 1, 1, 15);   // never strobed
            end
        join
    endtask

    task automatic t_max();
        program_held(mk(63, 1024, 0, 0, 0, 0, 0));
        watch("R12", 1024, 63, 1'b0, 4200);
    endtask

    task automatic t_ignore();
        @(negedge clk);
        cfg = mk(0, 4, 0, 1, 0, 0, 0); upd = 1'b1; sync = 1'b1;
        fork
            watch("R6", 4, 0, 1'b0, 48);
            begin
                @(negedge clk);
                upd = 1'b0;
                repeat (10) @(negedge clk);
                sync = 1'b0;
                repeat (4) @(negedge clk);
                sync = 1'b1;
                repeat (3) @(negedge clk);
                sync = 1'b0;
            end
        join
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_even();
        t_odd();
        t_phase();
        t_invert();
        t_power();
        t_shadow();
        t_max();
        t_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule